// File: doc/BRIEF.md
# Offset Min-Sum Check Node Unit

This block performs the check-node update of a quasi-cyclic LDPC decoder that runs the offset min-sum rule. The variable-to-check messages of one check row arrive one edge per handshake. When the row closes, the block returns one check-to-variable message per edge, in the order the edges arrived. Each returned message has the sign parity of all the other edges of the row. Its magnitude is the smallest magnitude among those other edges, reduced by an offset and held at zero or above.

Three code rates share this one datapath. A two-bit mode, taken with the first edge of each row, selects the offset for that row. A decoder can therefore feed rows of blocks with different rates back to back, with no reset between them. Internally the block keeps each row in registers and tracks the smallest magnitude, the second smallest magnitude, the position of the smallest, and the overall sign parity. No per-edge search is needed on the output side.

Top module: `oms_check_node`

## Requirements
- R1: A message is 6-bit sign-magnitude. Bit 5 is the sign (1 = negative). Bits 4:0 are an unsigned magnitude with 2 fractional bits (LSB = 0.25), so the largest magnitude is 31 (7.75).
- R2: For edge i of a row, the output magnitude is max(0, m - offset), where m is the minimum input magnitude over all other edges of the row. In a row of one edge, m is taken as 31.
- R3: The output sign is the XOR of the sign bits of all other edges of the row. An output whose magnitude is 0 always carries sign bit 0, and this includes the case where an input is a negative zero (6'b100000).
- R4: The offset is 4 (1.0) for mode 0 (rate 7/8), 3 (0.75) for mode 1 (rate 3/4), 2 (0.5) for mode 2 (rate 1/2), and 4 for mode 3.
- R5: The mode is sampled with the first edge of a row. The value of in_mode on any later edge of that row has no effect on its outputs.
- R6: When several edges share the smallest magnitude, each of them receives that same magnitude less the offset.
- R7: The first output of a row is valid in the cycle after the row's closing edge is accepted. Outputs come one per handshake in input order, and out_last marks the final one. Their count equals the row degree.
- R8: While out_valid is high and out_ready is low, out_valid, out_msg and out_last stay unchanged into the next cycle.
- R9: in_ready is low while a row's outputs are pending. The only exception is the cycle of the final output handshake, in which the first edge of the next row may be accepted. That next row uses its own mode.
- R10: A row closes after MAX_DEG (default 32) edges even when in_last is not asserted.
- R11: Out of reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input edge present |
| in_ready | output | 1 | Block accepts an input edge |
| in_msg | input | 6 | Variable-to-check message, sign-magnitude |
| in_last | input | 1 | Edge closes the current row |
| in_mode | input | 2 | Rate mode, sampled on a row's first edge |
| out_valid | output | 1 | Output edge present |
| out_ready | input | 1 | Downstream accepts the output edge |
| out_msg | output | 6 | Check-to-variable message, sign-magnitude |
| out_last | output | 1 | Final output edge of the row |

## Verification
Two things can happen in the same clock edge: the final output handshake of one row, and the acceptance of the first edge of the next row. That next edge carries a different mode. The bench provokes this by queuing the second row's first edge while the first row is still draining with out_ready held high. It then checks that the acceptance cycle equals the final-output cycle. It also checks that every output of the first row still uses the old offset, and that every output of the second row uses the new one. A second stress case withholds out_ready on a fixed pattern during a row and checks that the stalled output holds.

// File: rtl/oms_pkg.sv
package oms_pkg;

   typedef enum logic [1:0] {
      MODE_R78   = 2'd0,
      MODE_R34   = 2'd1,
      MODE_R12   = 2'd2,
      MODE_SPARE = 2'd3
   } code_rate_e;

endpackage

// File: rtl/oms_offset_sel.sv
module oms_offset_sel #(
   parameter int MAG_W   = 5,
   parameter int OFF_R78 = 4,
   parameter int OFF_R34 = 3,
   parameter int OFF_R12 = 2
) (
   input  oms_pkg::code_rate_e mode,
   output logic [MAG_W-1:0]    offset
);
   import oms_pkg::*;

   localparam int MAX_MAG = (1 << MAG_W) - 1;

   if (OFF_R78 < 0 || OFF_R78 > MAX_MAG) begin : g_bad_r78
      $error("oms_offset_sel: OFF_R78 outside magnitude range");
   end
   if (OFF_R34 < 0 || OFF_R34 > MAX_MAG) begin : g_bad_r34
      $error("oms_offset_sel: OFF_R34 outside magnitude range");
   end
   if (OFF_R12 < 0 || OFF_R12 > MAX_MAG) begin : g_bad_r12
      $error("oms_offset_sel: OFF_R12 outside magnitude range");
   end

   always_comb begin
      unique case (mode)
         MODE_R34: offset = MAG_W'(OFF_R34);
         MODE_R12: offset = MAG_W'(OFF_R12);
         default:  offset = MAG_W'(OFF_R78);
      endcase
   end

endmodule

// File: rtl/oms_min_track.sv
module oms_min_track #(
   parameter int MAG_W = 5,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             first,
   input  logic             sgn,
   input  logic [MAG_W-1:0] mag,
   input  logic [IDX_W-1:0] eidx,
   output logic [MAG_W-1:0] min1,
   output logic [MAG_W-1:0] min2,
   output logic [IDX_W-1:0] min_idx,
   output logic             parity
);
   localparam logic [MAG_W-1:0] MAX_MAG = {MAG_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min1    <= MAX_MAG;
         min2    <= MAX_MAG;
         min_idx <= '0;
         parity  <= 1'b0;
      end else if (upd) begin
         if (first) begin
            min1    <= mag;
            min2    <= MAX_MAG;
            min_idx <= eidx;
            parity  <= sgn;
         end else begin
            parity <= parity ^ sgn;
            if (mag < min1) begin
               min2    <= min1;
               min1    <= mag;
               min_idx <= eidx;
            end else if (mag < min2) begin
               min2 <= mag;
            end
         end
      end
   end

endmodule

// File: rtl/oms_edge_store.sv
module oms_edge_store #(
   parameter int DEPTH = 32,
   parameter int MSG_W = 6,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [MSG_W-1:0] wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic [MSG_W-1:0] rdata
);
   logic [DEPTH*MSG_W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [MSG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we && (waddr == IDX_W'(g))) begin
            q <= wdata;
         end
      end
      assign flat[g*MSG_W +: MSG_W] = q;
   end

   assign rdata = flat[int'(raddr)*MSG_W +: MSG_W];

endmodule

// File: rtl/oms_out_calc.sv
module oms_out_calc #(
   parameter int MSG_W = 6,
   parameter int IDX_W = 5
) (
   input  logic [MSG_W-2:0] min1,
   input  logic [MSG_W-2:0] min2,
   input  logic [IDX_W-1:0] min_idx,
   input  logic             parity,
   input  logic [IDX_W-1:0] eidx,
   input  logic             esgn,
   input  logic [MSG_W-2:0] offset,
   output logic [MSG_W-1:0] msg
);
   localparam int MAG_W = MSG_W - 1;

   logic [MAG_W-1:0] other;
   logic [MAG_W-1:0] mag;
   logic             sgn;

   always_comb begin
      other = (eidx == min_idx) ? min2 : min1;
      mag   = (other > offset) ? (other - offset) : '0;
      sgn   = (mag != '0) && (parity ^ esgn);
      msg   = {sgn, mag};
   end

endmodule

// File: rtl/oms_check_node.sv
module oms_check_node #(
   parameter int MSG_W   = 6,
   parameter int MAX_DEG = 32,
   parameter int OFF_R78 = 4,
   parameter int OFF_R34 = 3,
   parameter int OFF_R12 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [MSG_W-1:0] in_msg,
   input  logic             in_last,
   input  logic [1:0]       in_mode,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [MSG_W-1:0] out_msg,
   output logic             out_last
);
   import oms_pkg::*;

   localparam int MAG_W = MSG_W - 1;
   localparam int IDX_W = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_DEG - 1);

   if (MSG_W < 2) begin : g_bad_msg
      $error("oms_check_node: MSG_W must be at least 2");
   end
   if (MAX_DEG < 2) begin : g_bad_deg
      $error("oms_check_node: MAX_DEG must be at least 2");
   end

   logic             acc_in;
   logic             acc_out;
   logic             fin_out;
   logic             first_edge;
   logic             row_end;
   logic             out_phase;
   logic [IDX_W-1:0] cnt;
   logic [IDX_W-1:0] deg_last;
   logic [IDX_W-1:0] out_idx;
   code_rate_e       mode_q;

   logic [MAG_W-1:0] min1;
   logic [MAG_W-1:0] min2;
   logic [IDX_W-1:0] min_idx;
   logic             parity;
   logic [MAG_W-1:0] offset;
   logic [MSG_W-1:0] edge_msg;

   assign acc_out    = out_valid && out_ready;
   assign fin_out    = acc_out && out_last;
   assign in_ready   = !out_phase || fin_out;
   assign acc_in     = in_valid && in_ready;
   assign first_edge = (cnt == '0);
   assign row_end    = in_last || (cnt == LAST_IDX);

   assign out_valid  = out_phase;
   assign out_last   = out_phase && (out_idx == deg_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         deg_last  <= '0;
         out_idx   <= '0;
         out_phase <= 1'b0;
         mode_q    <= MODE_R78;
      end else begin
         if (acc_in) begin
            cnt <= row_end ? '0 : cnt + 1'b1;
            if (first_edge) begin
               mode_q <= code_rate_e'(in_mode);
            end
            if (row_end) begin
               deg_last <= cnt;
            end
         end
         if (acc_in && row_end) begin
            out_phase <= 1'b1;
            out_idx   <= '0;
         end else if (fin_out) begin
            out_phase <= 1'b0;
         end else if (acc_out) begin
            out_idx <= out_idx + 1'b1;
         end
      end
   end

   oms_edge_store #(
      .DEPTH (MAX_DEG),
      .MSG_W (MSG_W),
      .IDX_W (IDX_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (acc_in),
      .waddr (cnt),
      .wdata (in_msg),
      .raddr (out_idx),
      .rdata (edge_msg)
   );

   oms_min_track #(
      .MAG_W (MAG_W),
      .IDX_W (IDX_W)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (acc_in),
      .first   (first_edge),
      .sgn     (in_msg[MSG_W-1]),
      .mag     (in_msg[MAG_W-1:0]),
      .eidx    (cnt),
      .min1    (min1),
      .min2    (min2),
      .min_idx (min_idx),
      .parity  (parity)
   );

   oms_offset_sel #(
      .MAG_W   (MAG_W),
      .OFF_R78 (OFF_R78),
      .OFF_R34 (OFF_R34),
      .OFF_R12 (OFF_R12)
   ) u_offset (
      .mode   (mode_q),
      .offset (offset)
   );

   oms_out_calc #(
      .MSG_W (MSG_W),
      .IDX_W (IDX_W)
   ) u_calc (
      .min1    (min1),
      .min2    (min2),
      .min_idx (min_idx),
      .parity  (parity),
      .eidx    (out_idx),
      .esgn    (edge_msg[MSG_W-1]),
      .offset  (offset),
      .msg     (out_msg)
   );

endmodule

// File: rtl/oms_check_node_chk.sv
module oms_check_node_chk #(
   parameter int MSG_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_last,
   input logic             out_valid,
   input logic             out_ready,
   input logic [MSG_W-1:0] out_msg,
   input logic             out_last
);

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_msg) && $stable(out_last)))
      else $error("hold_stable_chk");

   // R7
   first_out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> out_valid)
      else $error("first_out_latency_chk");

   // R9
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(out_ready && out_last)) |-> !in_ready)
      else $error("busy_block_chk");

   // R9
   idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready)
      else $error("idle_accept_chk");

   // R3
   zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_msg[MSG_W-2:0] == '0)) |-> !out_msg[MSG_W-1])
      else $error("zero_sign_chk");

endmodule

bind oms_check_node oms_check_node_chk #(.MSG_W(MSG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_msg   (out_msg),
   .out_last  (out_last)
);

// File: tb/oms_check_node_bench.sv
`timescale 1ns/1ps
module oms_check_node_bench;
   localparam int MAXD = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [5:0] in_msg = '0;
   logic       in_last = 1'b0;
   logic [1:0] in_mode = '0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [5:0] out_msg;
   logic       out_last;

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   oms_check_node u_oms_check_node (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_msg(in_msg), .in_last(in_last), .in_mode(in_mode),
      .out_valid(out_valid), .out_ready(out_ready), .out_msg(out_msg),
      .out_last(out_last));

   int n_tests = 0;
   int n_fail  = 0;

   logic [5:0] rows [0:1][0:MAXD-1];
   int    rdeg [0:1];
   int    rmode [0:1];
   int    rlate [0:1];
   bit    ruse_last [0:1];
   string rtag [0:1];
   int    acc_first [0:1];
   int    acc_last [0:1];
   int    out_first [0:1];
   int    out_final [0:1];
   int    rdy_mode = 0;

   task automatic check(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int off_of(int m);
      if (m == 1) return 3;
      if (m == 2) return 2;
      return 4;
   endfunction

   function automatic logic [5:0] expect_msg(int r, int i);
      int mn = 31;
      bit p = 1'b0;
      int o;
      for (int j = 0; j < rdeg[r]; j++) begin
         if (j != i) begin
            if (int'(rows[r][j][4:0]) < mn) mn = int'(rows[r][j][4:0]);
            p = p ^ rows[r][j][5];
         end
      end
      o = mn - off_of(rmode[r]);
      if (o < 0) o = 0;
      return {(o != 0) ? p : 1'b0, 5'(o)};
   endfunction

   task automatic set_row(int r, int deg, int mode, bit use_last, string tag);
      rdeg[r] = deg; rmode[r] = mode; rlate[r] = mode;
      ruse_last[r] = use_last; rtag[r] = tag;
   endtask

   task automatic load(int r, int i, int v);
      rows[r][i] = (v < 0) ? {1'b1, 5'(-v)} : {1'b0, 5'(v)};
   endtask

   task automatic send_rows(int first, int cnt);
      for (int r = first; r < first + cnt; r++) begin
         for (int i = 0; i < rdeg[r]; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_msg   = rows[r][i];
            in_last  = ruse_last[r] && (i == rdeg[r] - 1);
            in_mode  = 2'((i == 0) ? rmode[r] : rlate[r]);
            #1;
            while (!in_ready) begin
               @(negedge clk);
               #1;
            end
            if (i == 0) acc_first[r] = cyc;
            acc_last[r] = cyc;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic recv_rows(int first, int cnt);
      for (int r = first; r < first + cnt; r++) begin
         int k = 0;
         bit held = 1'b0;
         logic [5:0] hmsg = '0;
         while (k < rdeg[r]) begin
            @(negedge clk);
            out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            #1;
            if (held) check(out_valid && out_msg == hmsg, "R8 stalled output held", int'(out_msg), int'(hmsg));
            held = 1'b0;
            if (out_valid && out_ready) begin
               check(out_msg == expect_msg(r, k), rtag[r], int'(out_msg), int'(expect_msg(r, k)));
               check(out_last == (k == rdeg[r] - 1), ruse_last[r] ? "R7 out_last position" : "R10 forced close out_last",
                     int'(out_last), int'(k == rdeg[r] - 1));
               if (k == 0) out_first[r] = cyc;
               if (k == rdeg[r] - 1) out_final[r] = cyc;
               k++;
            end else if (out_valid) begin
               held = 1'b1;
               hmsg = out_msg;
            end
         end
      end
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic run(int first, int cnt);
      fork
         send_rows(first, cnt);
         recv_rows(first, cnt);
      join
      @(negedge clk);
      #1;
      check(!out_valid && in_ready, "R7 no extra output after row", int'(out_valid), 0);
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      check(!out_valid, "R11 out_valid in reset", int'(out_valid), 0);
      check(in_ready, "R11 in_ready in reset", int'(in_ready), 1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      check(!out_valid && in_ready, "R11 idle after reset", int'(out_valid), 0);
   endtask

   task automatic t_basic();
      set_row(0, 6, 0, 1'b1, "R1 R2 R3 basic row");
      load(0, 0, 10); load(0, 1, -5); load(0, 2, 20);
      load(0, 3, 7);  load(0, 4, -31); load(0, 5, 12);
      run(0, 1);
      check(out_first[0] == acc_last[0] + 1, "R7 first output latency", out_first[0] - acc_last[0], 1);
   endtask

   task automatic t_modes();
      for (int m = 1; m < 4; m++) begin
         set_row(0, 5, m, 1'b1, "R4 offset per mode");
         load(0, 0, -9); load(0, 1, 4); load(0, 2, 14);
         load(0, 3, -3); load(0, 4, 6);
         run(0, 1);
      end
   endtask

   task automatic t_tie_zero();
      set_row(0, 4, 2, 1'b1, "R6 tied minimum");
      load(0, 0, -6); load(0, 1, 6); load(0, 2, 9); load(0, 3, 14);
      run(0, 1);
      set_row(0, 4, 2, 1'b1, "R3 negative zero input");
      rows[0][0] = 6'b100000;
      load(0, 1, -3); load(0, 2, 8); load(0, 3, 9);
      run(0, 1);
   endtask

   task automatic t_deg1();
      set_row(0, 1, 2, 1'b1, "R2 single edge row");
      load(0, 0, -20);
      run(0, 1);
   endtask

   task automatic t_late_mode();
      set_row(0, 5, 2, 1'b1, "R5 later mode ignored");
      rlate[0] = 0;
      load(0, 0, 11); load(0, 1, -8); load(0, 2, 17);
      load(0, 3, 25); load(0, 4, -13);
      run(0, 1);
   endtask

   task automatic t_backpressure();
      rdy_mode = 1;
      set_row(0, 8, 1, 1'b1, "R8 values under stall");
      for (int i = 0; i < 8; i++) load(0, i, ((i % 3) == 0) ? -(i * 3 + 5) : (i * 3 + 5));
      run(0, 1);
      rdy_mode = 0;
   endtask

   task automatic t_overlap();
      set_row(0, 5, 0, 1'b1, "R9 first row old mode");
      load(0, 0, 13); load(0, 1, -7); load(0, 2, 22); load(0, 3, -9); load(0, 4, 30);
      set_row(1, 4, 2, 1'b1, "R9 second row new mode");
      load(1, 0, -4); load(1, 1, 18); load(1, 2, -11); load(1, 3, 6);
      run(0, 2);
      check(acc_first[1] == out_final[0], "R9 accept during final output", acc_first[1], out_final[0]);
      check(out_first[1] == acc_last[1] + 1, "R7 latency of second row", out_first[1] - acc_last[1], 1);
   endtask

   task automatic t_maxdeg();
      set_row(0, MAXD, 1, 1'b0, "R10 full degree values");
      for (int i = 0; i < MAXD; i++) load(0, i, ((i % 2) == 1) ? -((i * 7) % 29 + 3) : ((i * 7) % 29 + 3));
      run(0, 1);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_modes();
      t_tie_zero();
      t_deg1();
      t_late_mode();
      t_backpressure();
      t_overlap();
      t_maxdeg();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule